// File: doc/BRIEF.md
# Dot-Matrix Refresh Scanner with Cursor

This block multiplexes four character cells, each a grid of five columns by seven rows, 140 dots in all. It walks through the seven rows in turn. For each row it looks up the five-dot column pattern of every digit's stored 7-bit character code through a glyph-lookup port, and drives a row-select index and five column lines per digit. The font table itself is outside the block. The lookup port takes a code and a row index and answers one clock later. The block asks for the four digits one after another during the row slot before the row is shown.

Any digit can be replaced by a cursor. A cursor is the full cell of 35 dots at half brightness. The cursor appears only when the global cursor-enable input is high and that digit's cursor bit is set. Half brightness comes from lighting the cursor cell on every other scan frame. A blanking controller supplies one enable per digit, and a low enable darkens that digit's columns.

Top module: `dmx_refresh_scanner`

## Requirements
- R1: While reset is held, `row_sel` is 6 (the last row) and every bit of `col_out` is 0.
- R2: `row_sel` changes exactly once every SLOT_TICKS clock cycles (default 8). It counts 0,1,…,6 and then returns to 0. After reset the first change sets it to 0.
- R3: With no cursor shown and all digits enabled, the slice `col_out[5*d +: 5]` shown while `row_sel` = r equals the glyph-port answer for digit d's code (bits `7*d +: 7` of `char_codes`) at row index r. That answer is bit c for column c, returned one cycle after the request.
- R4: When `cursor_en` is 1, every digit whose bit in `cursor_bits` is 1 shows the cursor pattern instead of its glyph. Digits whose bit is 0 show their glyph.
- R5: When `cursor_en` is 0, every digit shows its glyph whatever `cursor_bits` holds.
- R6: A cursor digit drives all five columns to 1 on the first frame after reset and on every second frame after that. It drives them all to 0 on the frames between. A frame begins when `row_sel` becomes 0.
- R7: One clock after `digit_en[d]` is sampled low, the slice of `col_out` for digit d is 0, and the other digits are unaffected. When the enable returns high, the digit shows its pattern again one clock later.
- R8: Between row changes, `col_out` stays constant unless `digit_en` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_codes | input | 28 | Character code of each digit, 7 bits per digit, digit 0 in the low bits |
| cursor_bits | input | 4 | Per-digit cursor request |
| cursor_en | input | 1 | Global cursor enable |
| digit_en | input | 4 | Per-digit light enable from the blanking controller |
| glyph_code | output | 7 | Code presented to the glyph lookup |
| glyph_row | output | 3 | Row index presented to the glyph lookup |
| glyph_cols | input | 5 | Column pattern returned by the lookup, one cycle after the request |
| row_sel | output | 3 | Row currently driven |
| col_out | output | 20 | Column lines, 5 per digit, digit 0 in the low bits |

## Verification
The bench checks that every row of every digit comes from the correct lookup answer. If the capture were off by one cycle, or the row index wrong, the wrong code's or row's dots would appear. It runs the cursor over two consecutive frames: a design without the frame toggle would show a full-bright cursor, and a design with the parity inverted would light the frames that should be dark. It also drops one digit's enable in the middle of a row to make sure the blanking hits only that digit, one cycle later. It measures the slot length and the wrap from row 6 back to 0, which catches off-by-one terminal counts.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
   // Increment with wrap to zero after the given last value.
   function automatic logic [7:0] wrap_next(input logic [7:0] cur, input logic [7:0] last);
      return (cur == last) ? 8'd0 : cur + 8'd1;
   endfunction
endpackage

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer #(
   parameter int SLOT_TICKS = 8,
   parameter int NUM_ROWS   = 7,
   parameter int ROW_W      = 3,
   parameter int TK_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TK_W-1:0]  tick,
   output logic             slot_end,
   output logic [ROW_W-1:0] row,
   output logic [ROW_W-1:0] row_next,
   output logic             frame_par
);
   logic [TK_W-1:0]  tk_q;
   logic [ROW_W-1:0] row_q;
   logic             frame_q;

   assign tick      = tk_q;
   assign row       = row_q;
   assign frame_par = frame_q;
   assign slot_end  = (tk_q == TK_W'(SLOT_TICKS-1));
   assign row_next  = ROW_W'(dmx_pkg::wrap_next(8'(row_q), 8'(NUM_ROWS-1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tk_q    <= '0;
         row_q   <= ROW_W'(NUM_ROWS-1);
         frame_q <= 1'b1;
      end else begin
         tk_q <= slot_end ? '0 : tk_q + TK_W'(1);
         if (slot_end) begin
            row_q <= row_next;
            if (row_next == '0) frame_q <= ~frame_q;
         end
      end
   end

   p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= ROW_W'(NUM_ROWS-1));
   p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_end |=> $stable(row_q));
   p_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(row_q) && row_q == '0) |-> $past(row_q) == ROW_W'(NUM_ROWS-1));
   p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(row_q) && row_q != '0) |-> row_q == $past(row_q) + ROW_W'(1));
endmodule

// File: rtl/dmx_glyph_fetch.sv
module dmx_glyph_fetch #(
   parameter int NUM_DIGITS = 4,
   parameter int CODE_W     = 7,
   parameter int NUM_COLS   = 5,
   parameter int ROW_W      = 3,
   parameter int TK_W       = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [TK_W-1:0]                tick,
   input  logic [ROW_W-1:0]               row_next,
   input  logic [NUM_DIGITS*CODE_W-1:0]   char_codes,
   input  logic [NUM_COLS-1:0]            glyph_cols,
   output logic [CODE_W-1:0]              glyph_code,
   output logic [ROW_W-1:0]               glyph_row,
   output logic [NUM_DIGITS*NUM_COLS-1:0] shadow
);
   localparam int DIG_W = $clog2(NUM_DIGITS);

   logic                                   req;
   logic [DIG_W-1:0]                       idx;
   logic                                   pend_q;
   logic [DIG_W-1:0]                       pidx_q;
   logic [NUM_DIGITS-1:0][NUM_COLS-1:0]    shad_q;

   // Digit d is requested at tick d of the slot; the answer is taken the cycle after.
   assign req        = (tick < TK_W'(NUM_DIGITS));
   assign idx        = tick[DIG_W-1:0];
   assign glyph_code = req ? char_codes[idx*CODE_W +: CODE_W] : '0;
   assign glyph_row  = row_next;
   assign shadow     = shad_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
         shad_q <= '0;
      end else begin
         pend_q <= req;
         pidx_q <= idx;
         if (pend_q) shad_q[pidx_q] <= glyph_cols;
      end
   end
endmodule

// File: rtl/dmx_col_drive.sv
module dmx_col_drive #(
   parameter int NUM_DIGITS = 4,
   parameter int NUM_COLS   = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic                           frame_par,
   input  logic [NUM_DIGITS*NUM_COLS-1:0] shadow,
   input  logic [NUM_DIGITS-1:0]          cursor_bits,
   input  logic                           cursor_en,
   input  logic [NUM_DIGITS-1:0]          digit_en,
   output logic [NUM_DIGITS*NUM_COLS-1:0] col_out
);
   logic [NUM_DIGITS*NUM_COLS-1:0] pat_q;
   logic [NUM_DIGITS-1:0]          cur_q;
   logic [NUM_DIGITS-1:0]          en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_q <= '0;
         cur_q <= '0;
         en_q  <= '0;
      end else begin
         en_q <= digit_en;
         if (load) begin
            pat_q <= shadow;
            cur_q <= cursor_bits & {NUM_DIGITS{cursor_en}};
         end
      end
   end

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      // Cursor cells light only on even-parity frames: half the on-time.
      assign col_out[d*NUM_COLS +: NUM_COLS] =
         !en_q[d]  ? '0 :
         cur_q[d]  ? {NUM_COLS{~frame_par}} :
                     pat_q[d*NUM_COLS +: NUM_COLS];

      p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !digit_en[d] |=> col_out[d*NUM_COLS +: NUM_COLS] == '0);
   end
endmodule

// File: rtl/dmx_refresh_scanner.sv
module dmx_refresh_scanner #(
   parameter int NUM_DIGITS = 4,
   parameter int NUM_COLS   = 5,
   parameter int NUM_ROWS   = 7,
   parameter int CODE_W     = 7,
   parameter int SLOT_TICKS = 8,
   localparam int ROW_W     = $clog2(NUM_ROWS),
   localparam int TK_W      = $clog2(SLOT_TICKS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_DIGITS*CODE_W-1:0]   char_codes,
   input  logic [NUM_DIGITS-1:0]          cursor_bits,
   input  logic                           cursor_en,
   input  logic [NUM_DIGITS-1:0]          digit_en,
   output logic [CODE_W-1:0]              glyph_code,
   output logic [ROW_W-1:0]               glyph_row,
   input  logic [NUM_COLS-1:0]            glyph_cols,
   output logic [ROW_W-1:0]               row_sel,
   output logic [NUM_DIGITS*NUM_COLS-1:0] col_out
);
   if (NUM_DIGITS < 2)              $error("NUM_DIGITS must be at least 2");
   if (SLOT_TICKS < NUM_DIGITS + 2) $error("SLOT_TICKS too short to fetch every digit");
   if (NUM_ROWS < 2 || ROW_W > 8)   $error("NUM_ROWS out of range");

   logic [TK_W-1:0]  tick;
   logic             slot_end;
   logic [ROW_W-1:0] row_next;
   logic             frame_par;
   logic [NUM_DIGITS*NUM_COLS-1:0] shadow;

   dmx_scan_timer #(
      .SLOT_TICKS(SLOT_TICKS), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .TK_W(TK_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slot_end(slot_end),
      .row(row_sel), .row_next(row_next), .frame_par(frame_par)
   );

   dmx_glyph_fetch #(
      .NUM_DIGITS(NUM_DIGITS), .CODE_W(CODE_W), .NUM_COLS(NUM_COLS),
      .ROW_W(ROW_W), .TK_W(TK_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .row_next(row_next),
      .char_codes(char_codes), .glyph_cols(glyph_cols),
      .glyph_code(glyph_code), .glyph_row(glyph_row), .shadow(shadow)
   );

   dmx_col_drive #(
      .NUM_DIGITS(NUM_DIGITS), .NUM_COLS(NUM_COLS)
   ) u_drive (
      .clk(clk), .rst_n(rst_n), .load(slot_end), .frame_par(frame_par),
      .shadow(shadow), .cursor_bits(cursor_bits), .cursor_en(cursor_en),
      .digit_en(digit_en), .col_out(col_out)
   );

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_end && $stable(digit_en)) |=> $stable(col_out));
endmodule

// File: tb/sim_dmx_refresh_scanner.sv
module sim_dmx_refresh_scanner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] char_codes = '0;
   logic [3:0]  cursor_bits = '0;
   logic        cursor_en = 1'b0;
   logic [3:0]  digit_en = 4'hF;
   logic [6:0]  glyph_code;
   logic [2:0]  glyph_row;
   logic [4:0]  glyph_cols;
   logic [2:0]  row_sel;
   logic [19:0] col_out;

   int checks = 0;
   int fails  = 0;
   int frames = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dmx_refresh_scanner u0 (
      .clk(clk), .rst_n(rst_n), .char_codes(char_codes), .cursor_bits(cursor_bits),
      .cursor_en(cursor_en), .digit_en(digit_en), .glyph_code(glyph_code),
      .glyph_row(glyph_row), .glyph_cols(glyph_cols), .row_sel(row_sel), .col_out(col_out)
   );

   function automatic logic [4:0] stub(input logic [6:0] c, input logic [2:0] r);
      return c[4:0] ^ {r[1:0], r};
   endfunction

   // Stub font: one-cycle registered lookup.
   always @(posedge clk) glyph_cols <= stub(glyph_code, glyph_row);

   // Frame counter from the port: a frame starts when row_sel becomes 0.
   always @(row_sel) if (rst_n && row_sel == 3'd0) frames++;

   function automatic logic [19:0] exp_cols(input logic [2:0] r, input bit lit);
      logic [19:0] e;
      for (int d = 0; d < 4; d++) begin
         if (!digit_en[d])                  e[d*5 +: 5] = 5'h00;
         else if (cursor_en && cursor_bits[d]) e[d*5 +: 5] = lit ? 5'h1F : 5'h00;
         else                               e[d*5 +: 5] = stub(char_codes[d*7 +: 7], r);
      end
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic goto_row(input logic [2:0] r);
      do @(negedge clk); while (row_sel == r);
      do @(negedge clk); while (row_sel != r);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 row_sel in reset", 32'(row_sel), 32'd6);
      chk("R1 col_out in reset", 32'(col_out), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_rows;
      logic [2:0] prev;
      int n = 0;
      int seen = 0;
      goto_row(3'd0);
      prev = row_sel;
      while (seen < 14) begin
         @(negedge clk);
         n++;
         if (row_sel != prev) begin
            chk("R2 slot length", 32'(n), 32'd8);
            chk("R2 row order", 32'(row_sel), (prev == 3'd6) ? 32'd0 : 32'(prev) + 32'd1);
            prev = row_sel;
            n = 0;
            seen++;
         end
      end
   endtask

   task automatic t_glyph(input string tag, input logic [27:0] codes, input logic [3:0] cb);
      char_codes  = codes;
      cursor_bits = cb;
      cursor_en   = 1'b0;
      digit_en    = 4'hF;
      goto_row(3'd6);
      for (int r = 0; r < 7; r++) begin
         goto_row(3'(r));
         chk(tag, 32'(col_out), 32'(exp_cols(3'(r), frames[0])));
      end
   endtask

   task automatic t_cursor;
      char_codes  = {7'h5A, 7'h33, 7'h0F, 7'h71};
      cursor_bits = 4'b0101;
      cursor_en   = 1'b1;
      goto_row(3'd6);
      goto_row(3'd3);
      chk("R4 R6 cursor frame A", 32'(col_out), 32'(exp_cols(3'd3, frames[0])));
      goto_row(3'd3);
      chk("R4 R6 cursor frame B", 32'(col_out), 32'(exp_cols(3'd3, frames[0])));
      goto_row(3'd3);
      chk("R6 cursor frame C", 32'(col_out), 32'(exp_cols(3'd3, frames[0])));
   endtask

   task automatic t_blank;
      cursor_en   = 1'b0;
      char_codes  = {7'h7F, 7'h15, 7'h6A, 7'h2C};
      goto_row(3'd6);
      goto_row(3'd2);
      digit_en = 4'b1101;
      @(negedge clk);
      chk("R7 digit 1 blanked", 32'(col_out), 32'(exp_cols(3'd2, 1'b0)));
      digit_en = 4'hF;
      @(negedge clk);
      chk("R7 digit 1 restored", 32'(col_out), 32'(exp_cols(3'd2, 1'b0)));
   endtask

   task automatic t_hold;
      logic [19:0] snap;
      goto_row(3'd4);
      snap = col_out;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R8 hold within slot", 32'(col_out), 32'(snap));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_rows();
      t_glyph("R3 glyph pattern A", {7'h41, 7'h1C, 7'h62, 7'h07}, 4'b0000);
      t_glyph("R3 glyph pattern B", {7'h13, 7'h7E, 7'h28, 7'h55}, 4'b0000);
      t_glyph("R5 cursor bits ignored", {7'h09, 7'h36, 7'h4B, 7'h70}, 4'b1111);
      t_cursor();
      t_blank();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule